// File: doc/BRIEF.md
# Refresh Address Generator

This block produces the row address that a processor places on its address bus during the memory refresh slot that follows every opcode fetch. It keeps a byte-wide refresh counter and a byte-wide page register. The lower seven bits of the counter advance once for each completed opcode fetch. The top bit of the counter only changes when software writes the counter. The page register supplies the high byte of the refresh address.

The surrounding CPU timing logic drives two strobes. `fetch_done` is high for one cycle per finished opcode fetch. `rfsh_cycle` is high for each cycle of the refresh slot, which is the time the fetched opcode is being decoded and executed. Software writes go through `ld_r` and `ld_i`, with the value on `wr_data`. The output side has no back-pressure: the DRAM side must accept the address in the cycle it is presented. The address and control outputs are registered, so they follow `rfsh_cycle` by one clock.

Top module: `rfsh_addr_gen`

## Requirements
- R1: After reset both the counter and the page register hold 0x00. While reset is active, `rfsh_addr` is 0x0000 and `rfsh_ctl` and `addr_valid` are 0.
- R2: Each clock edge at which `fetch_done` is high and `ld_r` is low adds one to counter bits [6:0].
- R3: Counting never changes counter bit 7. It keeps the value of bit 7 from the last `ld_r` write, or 0 after reset.
- R4: Counter bits [6:0] wrap from 0x7F to 0x00 without carrying into bit 7. For example, 0xFF steps to 0x80.
- R5: An edge with `ld_r` high loads `wr_data` into all eight counter bits. If `fetch_done` is high at the same edge, the loaded value wins.
- R6: An edge with `rfsh_cycle` high takes the values that the page register and counter held before that edge. In the next cycle `rfsh_addr` shows them as {page[7:0], counter[7:0]}, page in bits [15:8], and `rfsh_ctl` and `addr_valid` are both 1. A fetch at the same edge shows up only in the following refresh address.
- R7: After an edge with `rfsh_cycle` low, `rfsh_ctl` and `addr_valid` are 0 and `rfsh_addr` is 0x0000.
- R8: An edge with `ld_i` high loads `wr_data` into the page register. Fetch strobes never change the page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_done | input | 1 | One cycle per completed opcode fetch |
| rfsh_cycle | input | 1 | High for each cycle of the refresh slot |
| ld_r | input | 1 | Write `wr_data` into the refresh counter |
| ld_i | input | 1 | Write `wr_data` into the page register |
| wr_data | input | 8 | Write data for either register |
| rfsh_addr | output | 16 | Refresh address: page byte above, counter byte below |
| rfsh_ctl | output | 1 | Refresh control, high while the address is presented |
| addr_valid | output | 1 | The address output carries a refresh address |

## Verification
The assertions assume that every input is a known value at each clock edge and that reset is held low for at least one edge before the first strobe. No rule between the strobes is assumed, so `fetch_done`, `ld_r`, `ld_i` and `rfsh_cycle` may coincide in any combination. The stimulus drives every input to a defined level on the falling edge, starting while reset is still low. It exercises the coinciding cases on purpose: a load together with a fetch, a page write together with a fetch, and a refresh together with a fetch. The counter is observed only through refresh addresses, which the sweep requests for every byte value written to the counter.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int unsigned DEF_BYTE_W = 8;

  typedef enum logic [1:0] {
    R_HOLD = 2'd0,
    R_STEP = 2'd1,
    R_LOAD = 2'd2
  } r_upd_e;
endpackage

// File: rtl/rfsh_rcount.sv
module rfsh_rcount
  import rfsh_pkg::*;
#(
  parameter int unsigned BYTE_W = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_data_i,
  output logic [BYTE_W-1:0] r_o
);
  localparam int unsigned CNT_W = BYTE_W - 1;

  r_upd_e           sel;
  logic [CNT_W-1:0] cnt_q;
  logic             top_q;

  // a software write has priority over the fetch step
  always_comb begin
    if (load_i)      sel = R_LOAD;
    else if (step_i) sel = R_STEP;
    else             sel = R_HOLD;
  end

  // the low field wraps on its own width, so no carry reaches the top bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      top_q <= 1'b0;
    end else begin
      unique case (sel)
        R_LOAD: begin
          cnt_q <= load_data_i[CNT_W-1:0];
          top_q <= load_data_i[BYTE_W-1];
        end
        R_STEP:  cnt_q <= cnt_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign r_o = {top_q, cnt_q};
endmodule

// File: rtl/rfsh_page_reg.sv
module rfsh_page_reg
  import rfsh_pkg::*;
#(
  parameter int unsigned BYTE_W = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_data_i,
  output logic [BYTE_W-1:0] page_o
);
  logic [BYTE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      page_q <= '0;
    else if (load_i) page_q <= load_data_i;
  end

  assign page_o = page_q;
endmodule

// File: rtl/rfsh_addr_out.sv
module rfsh_addr_out
  import rfsh_pkg::*;
#(
  parameter int unsigned BYTE_W = DEF_BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_i,
  input  logic [BYTE_W-1:0]   page_i,
  input  logic [BYTE_W-1:0]   r_i,
  output logic [2*BYTE_W-1:0] addr_o,
  output logic                ctl_o,
  output logic                valid_o
);
  localparam int unsigned ADDR_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] addr_q;
  logic              live_q;

  // the bus is driven to zero outside the slot so nothing stale leaks out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      live_q <= 1'b0;
    end else begin
      live_q <= slot_i;
      addr_q <= slot_i ? {page_i, r_i} : '0;
    end
  end

  assign addr_o  = addr_q;
  assign ctl_o   = live_q;
  assign valid_o = live_q;
endmodule

// File: rtl/rfsh_addr_gen.sv
module rfsh_addr_gen
  import rfsh_pkg::*;
#(
  parameter int unsigned BYTE_W = DEF_BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_done,
  input  logic                rfsh_cycle,
  input  logic                ld_r,
  input  logic                ld_i,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [2*BYTE_W-1:0] rfsh_addr,
  output logic                rfsh_ctl,
  output logic                addr_valid
);
  logic [BYTE_W-1:0] r_val;
  logic [BYTE_W-1:0] i_val;

  rfsh_rcount #(.BYTE_W(BYTE_W)) rcount_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (fetch_done),
    .load_i      (ld_r),
    .load_data_i (wr_data),
    .r_o         (r_val)
  );

  rfsh_page_reg #(.BYTE_W(BYTE_W)) page_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (ld_i),
    .load_data_i (wr_data),
    .page_o      (i_val)
  );

  rfsh_addr_out #(.BYTE_W(BYTE_W)) out_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_i  (rfsh_cycle),
    .page_i  (i_val),
    .r_i     (r_val),
    .addr_o  (rfsh_addr),
    .ctl_o   (rfsh_ctl),
    .valid_o (addr_valid)
  );
endmodule

// File: rtl/rfsh_addr_gen_chk.sv
module rfsh_addr_gen_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fetch_done,
  input logic                rfsh_cycle,
  input logic                ld_r,
  input logic                ld_i,
  input logic [BYTE_W-1:0]   wr_data,
  input logic [BYTE_W-1:0]   r_q,
  input logic [BYTE_W-1:0]   i_q,
  input logic [2*BYTE_W-1:0] rfsh_addr,
  input logic                rfsh_ctl,
  input logic                addr_valid
);
  localparam int unsigned CNT_W = BYTE_W - 1;

  always_comb begin
    if (!rst_n) begin
      a_reset_out_r1: assert (rfsh_addr == '0 && !rfsh_ctl && !addr_valid);
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done && !ld_r) |=>
      r_q[CNT_W-1:0] == CNT_W'($past(r_q[CNT_W-1:0]) + 1'b1));

  p_top_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_r |=> r_q[BYTE_W-1] == $past(r_q[BYTE_W-1]));

  p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_r |=> r_q == $past(wr_data));

  p_slot_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_cycle |=> (addr_valid && rfsh_ctl &&
                    rfsh_addr == {$past(i_q), $past(r_q)}));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_cycle |=> (!addr_valid && !rfsh_ctl && rfsh_addr == '0));

  p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(i_q));

  p_page_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> i_q == $past(wr_data));
endmodule

bind rfsh_addr_gen rfsh_addr_gen_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_done (fetch_done),
  .rfsh_cycle (rfsh_cycle),
  .ld_r       (ld_r),
  .ld_i       (ld_i),
  .wr_data    (wr_data),
  .r_q        (r_val),
  .i_q        (i_val),
  .rfsh_addr  (rfsh_addr),
  .rfsh_ctl   (rfsh_ctl),
  .addr_valid (addr_valid)
);

// File: tb/rfsh_addr_gen_tb_top.sv
module rfsh_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_done;
  logic        rfsh_cycle;
  logic        ld_r;
  logic        ld_i;
  logic [7:0]  wr_data;
  logic [15:0] rfsh_addr;
  logic        rfsh_ctl;
  logic        addr_valid;

  int errs = 0;
  int nchk = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rfsh_addr_gen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_done (fetch_done),
    .rfsh_cycle (rfsh_cycle),
    .ld_r       (ld_r),
    .ld_i       (ld_i),
    .wr_data    (wr_data),
    .rfsh_addr  (rfsh_addr),
    .rfsh_ctl   (rfsh_ctl),
    .addr_valid (addr_valid)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk16(string tag, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // one refresh slot, then compare the presented address
  task automatic probe(string tag, logic [15:0] exp);
    rfsh_cycle = 1'b1;
    tick();
    rfsh_cycle = 1'b0;
    chk16(tag, rfsh_addr, exp);
    chk1(tag, addr_valid, 1'b1);
    chk1(tag, rfsh_ctl, 1'b1);
  endtask

  task automatic load_r(logic [7:0] v);
    ld_r = 1'b1; wr_data = v;
    tick();
    ld_r = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; fetch_done = 1'b0; rfsh_cycle = 1'b0;
    ld_r = 1'b0; ld_i = 1'b0; wr_data = 8'h00;
    @(negedge clk);
    tick();
    // R1: outputs held low while in reset
    chk16("R1 addr in reset", rfsh_addr, 16'h0000);
    chk1("R1 valid in reset", addr_valid, 1'b0);
    chk1("R1 ctl in reset", rfsh_ctl, 1'b0);
    rst_n = 1'b1;
    tick();
    probe("R1 registers cleared", 16'h0000);

    // R2: three fetches advance the counter by three
    fetch_done = 1'b1;
    repeat (3) tick();
    fetch_done = 1'b0;
    probe("R2 count after 3 fetches", 16'h0003);

    // R8: page write together with a fetch; the page is loaded, the counter steps
    ld_i = 1'b1; wr_data = 8'hA5; fetch_done = 1'b1;
    tick();
    ld_i = 1'b0; fetch_done = 1'b0;
    probe("R8 page load during fetch", 16'hA504);

    // R4: the low field wraps to zero
    load_r(8'h7F);
    fetch_done = 1'b1; tick(); fetch_done = 1'b0;
    probe("R4 wrap 7F", 16'hA500);
    // R3: bit 7 survives the wrap
    load_r(8'hFF);
    fetch_done = 1'b1; tick(); fetch_done = 1'b0;
    probe("R3 wrap keeps bit 7", 16'hA580);
    load_r(8'hFE);
    fetch_done = 1'b1; repeat (3) tick(); fetch_done = 1'b0;
    probe("R3 count across wrap", 16'hA581);

    // R5: load and fetch at the same edge, the load wins
    ld_r = 1'b1; wr_data = 8'h33; fetch_done = 1'b1;
    tick();
    ld_r = 1'b0; fetch_done = 1'b0;
    probe("R5 load beats fetch", 16'hA533);

    // R6: refresh at the same edge as a fetch shows the value before the step
    rfsh_cycle = 1'b1; fetch_done = 1'b1;
    tick();
    rfsh_cycle = 1'b0; fetch_done = 1'b0;
    chk16("R6 pre-step address", rfsh_addr, 16'hA533);
    chk1("R6 valid", addr_valid, 1'b1);
    probe("R6 post-step address", 16'hA534);

    // R7: idle slot with a fetch pending, the bus reads zero
    fetch_done = 1'b1;
    tick();
    fetch_done = 1'b0;
    chk16("R7 idle addr", rfsh_addr, 16'h0000);
    chk1("R7 idle valid", addr_valid, 1'b0);
    chk1("R7 idle ctl", rfsh_ctl, 1'b0);

    // sweep: every counter byte, varying step counts and page values
    for (int v = 0; v < 256; v++) begin
      logic [7:0] pg;
      logic [7:0] exp_r;
      int n;
      pg = 8'(v) ^ 8'h5A;
      n  = v % 5;
      ld_r = 1'b1; ld_i = 1'b1; wr_data = 8'(v);
      tick();
      ld_r = 1'b0; ld_i = 1'b0;
      wr_data = pg;
      ld_i = 1'b1;
      tick();
      ld_i = 1'b0;
      fetch_done = 1'b1;
      for (int k = 0; k < n; k++) tick();
      fetch_done = 1'b0;
      exp_r = {8'(v) & 8'h80} | {1'b0, 7'(v + n)};
      probe("R2 R3 R4 sweep", {pg, exp_r});
      tick();
      chk1("R7 sweep idle", addr_valid, 1'b0);
      chk16("R7 sweep idle addr", rfsh_addr, 16'h0000);
    end

    finish_run();
  end
endmodule